// File: doc/BRIEF.md
# MDIO Management Master

This block is the host side of the two-wire PHY management bus. Software programs a small register file with a PHY address, a register address and, for writes, sixteen bits of data. It then issues a read, write or continuous scan command. The block divides the system clock down to the management clock (MDC). It shifts out a clause 22 frame MSB first and drives the bidirectional data line (MDIO) through separate output and output-enable pins. For reads it lets go of the line during turnaround and data, and captures the sixteen bits the PHY returns.

Scan mode repeats reads of one PHY register back to back for as long as the scan command bit stays set. Each scan result updates the receive data and a link-fail flag. A status flag shows that no scan result has arrived yet. Busy covers the whole transaction, or the whole scan. Read data is valid in the same cycle that busy falls.

Top module: `mdio_master`

## Requirements
- R1: After reset every register reads 0, MDC is low and the master does not drive MDIO.
- R2: Registers are selected by index: 0 mode, 1 command, 2 address, 3 transmit data, 4 receive data, 5 status. Mode bits 7:0 set the divider with bit 0 ignored, and a resulting value below 2 counts as 2. MDC stays low for divider/2 system cycles and then high for divider/2 cycles, starting low in the cycle the transaction starts. It is held low when idle.
- R3: A frame with preamble is 64 bits: 32 ones, start 01, opcode (10 read, 01 write), PHY address from address register bits 4:0, register address from bits 12:8, two turnaround bits, 16 data bits, all MSB first. The line changes only after MDC falls.
- R4: Mode bit 8 set removes the preamble, giving a 32-bit frame with the same field order.
- R5: A write sends turnaround 10 and transmit-data bits 15:0, drives the line for the whole frame and leaves receive data unchanged.
- R6: A read releases the line for both turnaround bits and the 16 data bits. It samples MDIO at each rising MDC edge and places the 16 bits in receive data when busy falls.
- R7: Status bit 1 (busy) rises in the cycle after the command write. It falls after frame length × divider system cycles, together with the last falling MDC edge.
- R8: Command bit 2 starts a write and bit 1 a read, and write wins if both are set. A command write that sets bit 1 or 2 while a frame is active has no effect on the line, MDC or busy.
- R9: Command bit 0 starts scan mode: read frames of the addressed register follow each other with one idle system cycle between them, and busy stays high. Clearing bit 0 lets the current frame finish, after which busy falls.
- R10: Setting command bit 0 sets status bit 2 (invalid). The first completed scan frame clears it. Every completed scan frame sets status bit 0 (link fail) to the inverse of receive-data bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 3 | Register index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from reg_sel_i |
| mdc_o | output | 1 | Management clock |
| mdio_i | input | 1 | Resolved level of the data line |
| mdio_o | output | 1 | Data line drive value |
| mdio_oe_o | output | 1 | Data line drive enable |

## Verification
A wrong divider count shows within the first half period of MDC, because the bench compares MDC against the expected phase on every system cycle. A bit counter or length latch that goes astray moves the fall of busy and the end of MDC activity. It also shifts a field, and that appears at the first sampled bit that differs from the expected frame, or at a release of the data line one bit early or late. A scan flag or invalid/link-fail state that is stuck shows at the first scan frame boundary, through busy and the status bits.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int unsigned PRE_LEN  = 32;
  localparam int unsigned REGA_LSB = 8;
  localparam int unsigned CMD_SCAN = 0;
  localparam int unsigned CMD_RD   = 1;
  localparam int unsigned CMD_WR   = 2;
  localparam int unsigned ST_LINK  = 0;
  localparam int unsigned ST_BUSY  = 1;
  localparam int unsigned ST_INV   = 2;

  typedef enum logic [2:0] {
    SEL_MODE = 3'd0,
    SEL_CMD  = 3'd1,
    SEL_ADDR = 3'd2,
    SEL_TXD  = 3'd3,
    SEL_RXD  = 3'd4,
    SEL_STAT = 3'd5
  } reg_sel_e;
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             mdc_o,
  output logic             rise_o,
  output logic             fall_o
);
  localparam int unsigned HW = DIV_W - 1;

  logic [HW-1:0] half, cnt_q;
  logic          tick;
  logic          unused_div;

  assign unused_div = div_i[0];
  // bit 0 dropped: only even divider values are used
  assign half = (div_i[DIV_W-1:1] == '0) ? HW'(1) : div_i[DIV_W-1:1];
  assign tick = en_i && (cnt_q >= half - HW'(1));
  assign rise_o = tick && !mdc_o;
  assign fall_o = tick && mdc_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_o <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      mdc_o <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      mdc_o <= ~mdc_o;
    end else begin
      cnt_q <= cnt_q + HW'(1);
    end
  end

  p_idle_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !mdc_o);
  p_hold_between_ticks_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !rise_o && !fall_o) |=> $stable(mdc_o));
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              read_i,
  input  logic              nopre_i,
  input  logic [ADDR_W-1:0] phy_i,
  input  logic [ADDR_W-1:0] rega_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              mdio_i,
  output logic              active_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_o,
  output logic              mdio_o,
  output logic              mdio_oe_o
);
  import mdio_pkg::*;

  localparam int unsigned BODY = 6 + 2 * ADDR_W + DATA_W;
  localparam int unsigned TOT  = PRE_LEN + BODY;
  localparam int unsigned IW   = $clog2(TOT);

  logic [TOT-1:0]    sh_q;
  logic [IW-1:0]     idx_q, last_q, rel_idx, samp_idx;
  logic              rd_q, active_q, at_last;
  logic [DATA_W-1:0] rx_q;
  logic [BODY-1:0]   body;

  assign body     = {2'b01, (read_i ? 2'b10 : 2'b01), phy_i, rega_i, 2'b10, wdata_i};
  assign at_last  = (idx_q == last_q);
  assign rel_idx  = last_q - IW'(DATA_W + 1);
  assign samp_idx = last_q - IW'(DATA_W - 1);

  assign active_o  = active_q;
  assign done_o    = active_q && fall_i && at_last;
  assign rx_o      = rx_q;
  assign mdio_o    = sh_q[TOT-1];
  assign mdio_oe_o = active_q && !(rd_q && (idx_q >= rel_idx));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q     <= '0;
      idx_q    <= '0;
      last_q   <= '0;
      rd_q     <= 1'b0;
      active_q <= 1'b0;
      rx_q     <= '0;
    end else if (start_i) begin
      sh_q     <= nopre_i ? {body, {PRE_LEN{1'b0}}} : {{PRE_LEN{1'b1}}, body};
      idx_q    <= '0;
      last_q   <= nopre_i ? IW'(BODY - 1) : IW'(TOT - 1);
      rd_q     <= read_i;
      active_q <= 1'b1;
    end else if (active_q) begin
      if (rise_i && rd_q && (idx_q >= samp_idx))
        rx_q <= {rx_q[DATA_W-2:0], mdio_i};
      if (fall_i) begin
        if (at_last) begin
          active_q <= 1'b0;
        end else begin
          idx_q <= idx_q + IW'(1);
          sh_q  <= {sh_q[TOT-2:0], 1'b0};
        end
      end
    end
  end

  p_line_moves_on_fall_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && !fall_i) |=> $stable(mdio_o));
  p_rx_moves_on_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rise_i |=> $stable(rx_o));
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs #(
  parameter int unsigned REG_W  = 32,
  parameter int unsigned DIV_W  = 8,
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [2:0]        sel_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic              active_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] rx_i,
  output logic [DIV_W-1:0]  div_o,
  output logic              nopre_o,
  output logic [ADDR_W-1:0] phy_o,
  output logic [ADDR_W-1:0] rega_o,
  output logic [DATA_W-1:0] txd_o,
  output logic              start_o,
  output logic              read_o
);
  import mdio_pkg::*;

  logic [DIV_W:0]    mode_q;
  logic [2:0]        cmd_q;
  logic [ADDR_W-1:0] phy_q, rega_q;
  logic [DATA_W-1:0] txd_q, rxd_q;
  logic              scan_frame_q, frame_rd_q, invalid_q, linkfail_q;
  logic              cmd_wr, start_rw, start_scan, busy;
  logic              unused_wdata;

  assign unused_wdata = ^wdata_i;
  assign cmd_wr     = we_i && (reg_sel_e'(sel_i) == SEL_CMD);
  assign start_rw   = cmd_wr && !active_i && !cmd_q[CMD_SCAN]
                      && (wdata_i[CMD_WR] || wdata_i[CMD_RD]);
  assign start_scan = !active_i && cmd_q[CMD_SCAN];
  assign start_o    = start_rw || start_scan;
  assign read_o     = start_rw ? !wdata_i[CMD_WR] : 1'b1;
  assign busy       = active_i || cmd_q[CMD_SCAN];

  assign div_o   = mode_q[DIV_W-1:0];
  assign nopre_o = mode_q[DIV_W];
  assign phy_o   = phy_q;
  assign rega_o  = rega_q;
  assign txd_o   = txd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q       <= '0;
      cmd_q        <= '0;
      phy_q        <= '0;
      rega_q       <= '0;
      txd_q        <= '0;
      rxd_q        <= '0;
      scan_frame_q <= 1'b0;
      frame_rd_q   <= 1'b0;
      invalid_q    <= 1'b0;
      linkfail_q   <= 1'b0;
    end else begin
      if (we_i) begin
        case (reg_sel_e'(sel_i))
          SEL_MODE: mode_q <= wdata_i[DIV_W:0];
          SEL_CMD:  cmd_q  <= wdata_i[2:0];
          SEL_ADDR: begin
            phy_q  <= wdata_i[ADDR_W-1:0];
            rega_q <= wdata_i[REGA_LSB +: ADDR_W];
          end
          SEL_TXD:  txd_q  <= wdata_i[DATA_W-1:0];
          default: ;
        endcase
      end
      if (start_o) begin
        scan_frame_q <= start_scan;
        frame_rd_q   <= read_o;
      end
      if (done_i && frame_rd_q)
        rxd_q <= rx_i;
      if (done_i && scan_frame_q) begin
        linkfail_q <= ~rx_i[2];
        invalid_q  <= 1'b0;
      end
      if (cmd_wr && wdata_i[CMD_SCAN] && !cmd_q[CMD_SCAN])
        invalid_q <= 1'b1;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (reg_sel_e'(sel_i))
      SEL_MODE: rdata_o[DIV_W:0] = mode_q;
      SEL_CMD:  rdata_o[2:0] = cmd_q;
      SEL_ADDR: begin
        rdata_o[ADDR_W-1:0]        = phy_q;
        rdata_o[REGA_LSB +: ADDR_W] = rega_q;
      end
      SEL_TXD:  rdata_o[DATA_W-1:0] = txd_q;
      SEL_RXD:  rdata_o[DATA_W-1:0] = rxd_q;
      SEL_STAT: begin
        rdata_o[ST_LINK] = linkfail_q;
        rdata_o[ST_BUSY] = busy;
        rdata_o[ST_INV]  = invalid_q;
      end
      default: ;
    endcase
  end

  p_start_only_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> !active_i);
  p_invalid_clears_on_scan_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(invalid_q) |-> $past(done_i && scan_frame_q));
  p_link_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_i && scan_frame_q) |=> $stable(linkfail_q));
endmodule

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int unsigned REG_W  = 32,
  parameter int unsigned DIV_W  = 8,
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [2:0]       reg_sel_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             mdc_o,
  input  logic             mdio_i,
  output logic             mdio_o,
  output logic             mdio_oe_o
);
  logic [DIV_W-1:0]  div;
  logic              nopre, start, read, active, done, rise, fall;
  logic [ADDR_W-1:0] phy, rega;
  logic [DATA_W-1:0] txd, rx;

  mdio_regs #(.REG_W(REG_W), .DIV_W(DIV_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .sel_i(reg_sel_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .active_i(active), .done_i(done), .rx_i(rx),
    .div_o(div), .nopre_o(nopre), .phy_o(phy), .rega_o(rega), .txd_o(txd),
    .start_o(start), .read_o(read)
  );

  mdio_clkdiv #(.DIV_W(DIV_W)) u_clkdiv (
    .clk_i, .rst_ni, .en_i(active), .div_i(div),
    .mdc_o, .rise_o(rise), .fall_o(fall)
  );

  mdio_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .clk_i, .rst_ni,
    .start_i(start), .read_i(read), .nopre_i(nopre),
    .phy_i(phy), .rega_i(rega), .wdata_i(txd),
    .rise_i(rise), .fall_i(fall), .mdio_i,
    .active_o(active), .done_o(done), .rx_o(rx),
    .mdio_o, .mdio_oe_o
  );
endmodule

// File: tb/mdio_master_bench.sv
module mdio_master_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  sel = 3'd5;
  logic [31:0] wd = '0;
  wire  [31:0] rdat;
  wire         mdc, mo, moe;
  logic        phy_oe = 1'b0;
  logic        phy_val = 1'b0;
  wire         line = moe ? mo : (phy_oe ? phy_val : 1'b1);
  int          n_cmp = 0;
  int          n_bad = 0;

  always #5 clk = ~clk;

  mdio_master u_mdio_master (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(we), .reg_sel_i(sel), .reg_wdata_i(wd), .reg_rdata_o(rdat),
    .mdc_o(mdc), .mdio_i(line), .mdio_o(mo), .mdio_oe_o(moe)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic fbit(int j, bit r, bit np, logic [4:0] pa, logic [4:0] ra,
                                logic [15:0] d);
    logic [63:0] f;
    int          i;
    f = {32'hFFFF_FFFF, 2'b01, (r ? 2'b10 : 2'b01), pa, ra, 2'b10, d};
    i = np ? j + 32 : j;
    return f[63 - i];
  endfunction

  task automatic wr(logic [2:0] a, logic [31:0] v);
    @(negedge clk);
    we = 1'b1; sel = a; wd = v;
    @(negedge clk);
    we = 1'b0; sel = 3'd5;
  endtask

  task automatic rdreg(logic [2:0] a, output logic [31:0] v);
    sel = a;
    #1 v = rdat;
    sel = 3'd5;
    #1;
  endtask

  task automatic go(logic [31:0] c);
    @(negedge clk);
    we = 1'b1; sel = 3'd1; wd = c;
  endtask

  // per-cycle reference of one frame; k counts system cycles since the start edge
  task automatic run_frame(string tg, bit r, bit np, int h, logic [4:0] pa, logic [4:0] ra,
                           logic [15:0] d, bit end_busy, int stop_k, logic [31:0] stop_v);
    int n, len, j;
    n   = np ? 32 : 64;
    len = 2 * h * n;
    for (int k = 0; k <= len; k++) begin
      @(posedge clk);
      @(negedge clk);
      we = 1'b0; sel = 3'd5;
      #1;
      j = k / (2 * h);
      chk("R2 mdc phase", 32'(mdc), (k < len) ? 32'((k / h) % 2) : 32'd0);
      chk("R7 busy", 32'(rdat[1]), (k < len) ? 32'd1 : 32'(end_busy));
      if (k < len && (k % (2 * h)) == h) begin
        chk({tg, " line bit"}, 32'(line), 32'(fbit(j, r, np, pa, ra, d)));
        chk("R6 drive enable", 32'(moe), 32'(!(r && j >= n - 18)));
      end
      if (moe && phy_oe) begin
        n_cmp++; n_bad++;
        $display("FAIL R6: actual contention expected single driver");
      end
      phy_oe  = r && (j < n) && (j >= n - 17);
      phy_val = phy_oe ? fbit(j, r, np, pa, ra, d) : 1'b0;
      if (k == stop_k) begin
        we = 1'b1; sel = 3'd1; wd = stop_v;
      end
    end
    phy_oe = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rdreg(3'(a), v);
      chk("R1 register reset", v, 32'd0);
    end
    chk("R1 mdc low", 32'(mdc), 32'd0);
    chk("R1 not driving", 32'(moe), 32'd0);

    // R5 write with preamble, divider 4
    wr(3'd0, 32'd4);
    wr(3'd2, {19'd0, 5'h0A, 3'd0, 5'h13});
    wr(3'd3, 32'h0000_A5C3);
    rdreg(3'd2, v);
    chk("R3 address register layout", v, 32'h0000_0A13);
    go(32'd4);
    run_frame("R5", 1'b0, 1'b0, 2, 5'h13, 5'h0A, 16'hA5C3, 1'b0, -1, 32'd0);
    rdreg(3'd4, v);
    chk("R5 receive data untouched", v, 32'd0);

    // R3/R6 read with preamble, divider 7 (bit 0 ignored -> 6)
    wr(3'd0, 32'd7);
    wr(3'd2, {19'd0, 5'h1F, 3'd0, 5'h01});
    go(32'd2);
    run_frame("R3", 1'b1, 1'b0, 3, 5'h01, 5'h1F, 16'h3C96, 1'b0, -1, 32'd0);
    rdreg(3'd4, v);
    chk("R6 read result", v, 32'h0000_3C96);

    // R4 read without preamble, divider 0 -> 2
    wr(3'd0, 32'h0000_0100);
    wr(3'd2, {19'd0, 5'h05, 3'd0, 5'h1C});
    go(32'd2);
    run_frame("R4", 1'b1, 1'b1, 1, 5'h1C, 5'h05, 16'h8001, 1'b0, -1, 32'd0);
    rdreg(3'd4, v);
    chk("R4 read result", v, 32'h0000_8001);

    // R8 write wins over read; read command mid-frame ignored
    wr(3'd0, 32'h0000_0102);
    wr(3'd3, 32'h0000_0F0F);
    go(32'd6);
    run_frame("R8", 1'b0, 1'b1, 1, 5'h1C, 5'h05, 16'h0F0F, 1'b0, 10, 32'd2);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      #1;
      chk("R8 ignored command stays idle busy", 32'(rdat[1]), 32'd0);
      chk("R8 ignored command stays idle mdc", 32'(mdc), 32'd0);
    end
    rdreg(3'd4, v);
    chk("R8 receive data untouched", v, 32'h0000_8001);

    // R9/R10 scan
    go(32'd1);
    @(posedge clk);
    @(negedge clk);
    we = 1'b0; sel = 3'd5;
    #1;
    chk("R10 invalid after scan start", 32'(rdat[2]), 32'd1);
    chk("R9 busy at scan start", 32'(rdat[1]), 32'd1);
    run_frame("R9", 1'b1, 1'b1, 1, 5'h1C, 5'h05, 16'h0000, 1'b1, -1, 32'd0);
    chk("R10 invalid cleared", 32'(rdat[2]), 32'd0);
    chk("R10 link fail set", 32'(rdat[0]), 32'd1);
    chk("R9 busy held between scans", 32'(rdat[1]), 32'd1);
    rdreg(3'd4, v);
    chk("R9 scan result", v, 32'd0);
    run_frame("R9", 1'b1, 1'b1, 1, 5'h1C, 5'h05, 16'h0004, 1'b0, 5, 32'd0);
    chk("R10 link fail clear", 32'(rdat[0]), 32'd0);
    rdreg(3'd4, v);
    chk("R9 second scan result", v, 32'h0000_0004);
    repeat (4) @(negedge clk);
    #1;
    chk("R9 scan stopped mdc", 32'(mdc), 32'd0);
    chk("R9 scan stopped busy", 32'(rdat[1]), 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule